// File: doc/BRIEF.md
# UART Receive Queue with Level and Idle-Timeout Interrupts

This block sits between a UART receiver core and the processor bus. Each byte that the receiver hands over is stored in a 16-entry queue. Software reads the bytes back through a small register window. Two interrupt causes tell software when to read. A fill-level cause fires once the queue holds a programmable number of bytes. An idle-timeout cause fires when bytes are waiting but the line has been quiet for 32 bit periods. That second cause lets software find the end of a message whose length is not a multiple of the fill threshold.

The timeout only counts while unread bytes sit in the queue. If software drains the queue, any pending timeout is withdrawn. A message whose length is an exact multiple of the threshold is therefore emptied by the level interrupt and produces no timeout afterwards. Software that relies on the timeout to mark the end of a frame must allow for this.

Registers are selected by a 3-bit index. A read of the data index pops one byte. Reads of every other index have no side effect.

Top module: `rxq_irq_ctrl`

## Requirements
- R1: Bytes are returned in arrival order. A read of index 0 places the oldest byte in reg_rdata[7:0] and removes it. Up to 16 bytes are held.
- R2: Index 1 is the flag register: bit 4 = queue empty, bit 5 = queue full, bit 3 = sticky overrun. Any write to index 1 clears the overrun bit.
- R3: A byte arriving while 16 bytes are held is discarded, the held bytes are unchanged, and the overrun bit is set.
- R4: Index 2 holds a 3-bit level code with reset value 2. The codes 0, 1, 2, 3 and 4 select thresholds of 2, 4, 8, 12 and 14 bytes. Codes 5 to 7 act as 14.
- R5: Raw status bit 4 (index 4) becomes 1 one cycle after the fill reaches the threshold. It remains 1 while the fill is at or above the threshold, even if a clear is written.
- R6: Writing 1 to bit 4 or bit 6 of index 6 clears that raw bit once its cause has gone. After a timeout is cleared it does not return until a new byte arrives.
- R7: Raw status bit 6 becomes 1 on the 32nd bit_tick counted since the most recent byte arrived, provided the queue has not been empty in between.
- R8: Each arriving byte restarts the idle count from zero.
- R9: While the queue is empty no timeout is raised. Emptying the queue cancels a pending timeout within one cycle.
- R10: Index 3 is the mask (bits 4 and 6). Index 5 returns raw AND mask. irq is 1 exactly when any masked bit is 1.
- R11: A data read of an empty queue returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per serial bit period |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on index 0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Combined masked interrupt |

## Verification
A corrupted pointer or fill count shows up on the very next data read, as a byte out of order or a lost byte. It also shows one cycle later as a wrong empty or full flag. A wrong idle count or timer arming shows up as bit 6 rising one tick too early or too late around the 32nd tick, or as a timeout that appears after the queue was drained. The bench probes exactly those tick counts. A wrong threshold decode shifts the rise of bit 4 by whole bytes, and the bench checks this at the boundary byte of every level code.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned REG_W = 16;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_FLAG = 3'd1;
  localparam logic [2:0] A_LVL  = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_RAW  = 3'd4;
  localparam logic [2:0] A_MIS  = 3'd5;
  localparam logic [2:0] A_CLR  = 3'd6;

  localparam int unsigned B_RX    = 4;
  localparam int unsigned B_TO    = 6;
  localparam int unsigned F_OVR   = 3;
  localparam int unsigned F_EMPTY = 4;
  localparam int unsigned F_FULL  = 5;

  localparam logic [2:0] LVL_RESET = 3'd2;

  // Fill threshold in eighths of the queue depth for a level code.
  function automatic int unsigned lvl_eighths(logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned lvl_threshold(logic [2:0] code, int unsigned depth);
    return (depth * lvl_eighths(code)) / 8;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] din,
  input  logic          rd_req,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] fill,
  output logic          empty,
  output logic          full,
  output logic          wr_ok,
  output logic          wr_drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          rd_ok;

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign rd_ok   = rd_req && !empty;
  assign wr_ok   = wr_req && (!full || rd_ok);
  assign wr_drop = wr_req && !wr_ok;
  assign dout    = empty ? '0 : mem[rp];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      case ({wr_ok, rd_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int unsigned TO_BITS = 32,
  localparam int unsigned TW     = $clog2(TO_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          restart,
  input  logic          armed,
  output logic          fire,
  output logic [TW-1:0] idle
);
  // Saturates at TO_BITS so one quiet stretch yields a single event.
  assign fire = armed && !restart && bit_tick && (idle == TW'(TO_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                    idle <= '0;
    else if (restart || !armed)    idle <= '0;
    else if (bit_tick && idle != TW'(TO_BITS)) idle <= idle + 1'b1;
  end
endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [DW-1:0]    head,
  input  logic [CW-1:0]    fill,
  input  logic             empty,
  input  logic             full,
  input  logic             drop,
  input  logic             to_fire,
  output logic [REG_W-1:0] reg_rdata,
  output logic             lvl_hit,
  output logic             raw_rx,
  output logic             raw_to,
  output logic             mask_rx,
  output logic             mask_to,
  output logic             ovr,
  output logic             irq
);
  logic [2:0]       lvl_code;
  logic [CW-1:0]    thr;
  logic             clr_rx, clr_to;
  logic [REG_W-1:0] raw_vec, mask_vec, flag_vec;

  assign thr     = CW'(lvl_threshold(lvl_code, DEPTH));
  assign lvl_hit = (fill >= thr);
  assign clr_rx  = reg_wr && (reg_addr == A_CLR) && reg_wdata[B_RX];
  assign clr_to  = reg_wr && (reg_addr == A_CLR) && reg_wdata[B_TO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_code <= LVL_RESET;
      mask_rx  <= 1'b0;
      mask_to  <= 1'b0;
      raw_rx   <= 1'b0;
      raw_to   <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_LVL) lvl_code <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_MASK) begin
        mask_rx <= reg_wdata[B_RX];
        mask_to <= reg_wdata[B_TO];
      end
      raw_rx <= lvl_hit || (raw_rx && !clr_rx);
      if (empty)        raw_to <= 1'b0;
      else if (to_fire) raw_to <= 1'b1;
      else if (clr_to)  raw_to <= 1'b0;
      if (drop)                                ovr <= 1'b1;
      else if (reg_wr && reg_addr == A_FLAG)   ovr <= 1'b0;
    end
  end

  always_comb begin
    raw_vec        = '0;
    raw_vec[B_RX]  = raw_rx;
    raw_vec[B_TO]  = raw_to;
    mask_vec       = '0;
    mask_vec[B_RX] = mask_rx;
    mask_vec[B_TO] = mask_to;
    flag_vec          = '0;
    flag_vec[F_OVR]   = ovr;
    flag_vec[F_EMPTY] = empty;
    flag_vec[F_FULL]  = full;
  end

  assign irq = |(raw_vec & mask_vec);

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = {{(REG_W - DW){1'b0}}, head};
      A_FLAG:  reg_rdata = flag_vec;
      A_LVL:   reg_rdata = {{(REG_W - 3){1'b0}}, lvl_code};
      A_MASK:  reg_rdata = mask_vec;
      A_RAW:   reg_rdata = raw_vec;
      A_MIS:   reg_rdata = raw_vec & mask_vec;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned TO_BITS = 32,
  localparam int unsigned CW     = $clog2(DEPTH + 1),
  localparam int unsigned TW     = $clog2(TO_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          bit_tick,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          irq
);
  logic [DW-1:0] head_w;
  logic [CW-1:0] fill_w;
  logic [TW-1:0] idle_w;
  logic empty_w, full_w, pop_w, push_ok_w, drop_w, fire_w;
  logic lvl_hit_w, raw_rx_w, raw_to_w, mask_rx_w, mask_to_w, ovr_w;

  assign pop_w = reg_rd && (reg_addr == A_DATA);

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(rx_valid), .din(rx_byte), .rd_req(pop_w),
    .dout(head_w), .fill(fill_w), .empty(empty_w), .full(full_w),
    .wr_ok(push_ok_w), .wr_drop(drop_w)
  );

  rxq_idle_timer #(.TO_BITS(TO_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .restart(push_ok_w),
    .armed(!empty_w), .fire(fire_w), .idle(idle_w)
  );

  rxq_csr #(.DEPTH(DEPTH), .DW(DW)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .head(head_w), .fill(fill_w), .empty(empty_w),
    .full(full_w), .drop(drop_w), .to_fire(fire_w), .reg_rdata(reg_rdata),
    .lvl_hit(lvl_hit_w), .raw_rx(raw_rx_w), .raw_to(raw_to_w),
    .mask_rx(mask_rx_w), .mask_to(mask_to_w), .ovr(ovr_w), .irq(irq)
  );
endmodule

// File: rtl/rxq_irq_ctrl_chk.sv
module rxq_irq_ctrl_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fill,
  input logic          empty,
  input logic          full,
  input logic          drop,
  input logic          fire,
  input logic          lvl_hit,
  input logic          raw_rx,
  input logic          raw_to,
  input logic          mask_rx,
  input logic          mask_to,
  input logic          ovr,
  input logic          irq
);
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({empty, full}));
  a_r3_drop_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(fill));
  a_r3_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr);
  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hit |=> raw_rx);
  a_r9_fire_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !empty);
  a_r9_empty_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !raw_to);
  a_r10_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_rx && mask_rx) || (raw_to && mask_to)) |-> irq);
  a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!(raw_rx && mask_rx) && !(raw_to && mask_to)) |-> !irq);
endmodule

bind rxq_irq_ctrl rxq_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill(fill_w), .empty(empty_w), .full(full_w),
  .drop(drop_w), .fire(fire_w), .lvl_hit(lvl_hit_w), .raw_rx(raw_rx_w),
  .raw_to(raw_to_w), .mask_rx(mask_rx_w), .mask_to(mask_to_w), .ovr(ovr_w),
  .irq(irq)
);

// File: tb/rxq_irq_ctrl_test.sv
`timescale 1ns/1ps
module rxq_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        bit_tick = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] q[$];
  bit m_ovr = 0;

  always #2 clk = ~clk;

  rxq_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bit_tick(bit_tick), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic int exp_thr(int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 12;
      default: return 14;
    endcase
  endfunction

  function automatic logic [15:0] exp_flags();
    return 16'((q.size() == 0) << 4) | 16'((q.size() == 16) << 5) | 16'(m_ovr << 3);
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (q.size() < 16) q.push_back(b); else m_ovr = 1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 3'd1) m_ovr = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
  endtask

  task automatic pop(output logic [15:0] v);
    reg_addr = 3'd0; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic drain(string req);
    logic [15:0] v;
    while (q.size() > 0) begin
      pop(v);
      check(req, v, {8'h00, q.pop_front()});
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    peek(3'd1, v); check("R2 reset flags", v, 16'h0010);
    peek(3'd2, v); check("R4 reset level", v, 16'h0002);
    peek(3'd4, v); check("R5 reset raw", v, 16'h0000);
    check("R10 reset irq", {15'd0, irq}, 16'h0000);

    // R11: read of empty queue
    pop(v); check("R11 empty read data", v, 16'h0000);
    peek(3'd1, v); check("R11 flags unchanged", v, 16'h0010);

    // R5/R10: default threshold 8
    for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
    idle(2);
    peek(3'd4, v); check("R5 below threshold", v, 16'h0000);
    push(8'h17); idle(1);
    peek(3'd4, v); check("R5 at threshold", v & 16'h0010, 16'h0010);
    check("R10 irq masked off", {15'd0, irq}, 16'h0000);
    wr(3'd3, 16'h0050);
    peek(3'd5, v); check("R10 masked status", v & 16'h0010, 16'h0010);
    check("R10 irq on", {15'd0, irq}, 16'h0001);
    wr(3'd6, 16'h0010); idle(1);
    peek(3'd4, v); check("R5 clear ignored at level", v & 16'h0010, 16'h0010);
    // drain the exact-multiple burst: no timeout may follow (R9)
    drain("R1 order");
    wr(3'd6, 16'h0010); idle(1);
    peek(3'd4, v); check("R6 clear after drain", v, 16'h0000);
    ticks(40);
    peek(3'd4, v); check("R9 no timeout after drain", v, 16'h0000);
    check("R10 irq quiet", {15'd0, irq}, 16'h0000);

    // R7: timeout on 32nd tick
    push(8'hA1); push(8'hA2); push(8'hA3);
    ticks(31);
    peek(3'd4, v); check("R7 tick 31", v, 16'h0000);
    ticks(1);
    peek(3'd4, v); check("R7 tick 32", v, 16'h0040);
    check("R10 irq timeout", {15'd0, irq}, 16'h0001);
    wr(3'd6, 16'h0040); ticks(40);
    peek(3'd4, v); check("R6 no refire", v, 16'h0000);

    // R8: restart on push
    push(8'hB1); ticks(31); ticks(1);
    peek(3'd4, v); check("R8 fire after new byte", v, 16'h0040);
    wr(3'd6, 16'h0040);
    push(8'hB2); ticks(20); push(8'hB3); ticks(31);
    peek(3'd4, v); check("R8 restarted count", v, 16'h0000);
    ticks(1);
    peek(3'd4, v); check("R8 fire from last byte", v, 16'h0040);
    // R9: drain cancels pending timeout
    drain("R1 order");
    idle(1);
    peek(3'd4, v); check("R9 drain cancels", v, 16'h0000);

    // R3/R2: overrun
    for (int i = 0; i < 17; i++) push(8'h30 + 8'(i));
    idle(1);
    peek(3'd1, v); check("R3 full with overrun", v, 16'h0028);
    wr(3'd1, 16'h0000);
    peek(3'd1, v); check("R2 overrun cleared", v, 16'h0020);
    drain("R3 kept bytes");
    wr(3'd6, 16'h0050); idle(1);

    // R4: every level code
    for (int c = 0; c < 8; c++) begin
      wr(3'd2, 16'(c));
      peek(3'd2, v); check("R4 level readback", v, 16'(c));
      for (int i = 0; i < exp_thr(c) - 1; i++) push(8'(c * 16 + i));
      wr(3'd6, 16'h0010); idle(1);
      peek(3'd4, v); check("R4 below level", v & 16'h0010, 16'h0000);
      push(8'hEE); idle(1);
      peek(3'd4, v); check("R4 at level", v & 16'h0010, 16'h0010);
      drain("R1 order");
      wr(3'd6, 16'h0050); idle(1);
    end
    wr(3'd2, 16'h0002);
    wr(3'd3, 16'h0000);

    // random mix against the queue model
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 2));
      if (op == 0) push(8'($urandom));
      else if (op == 1) begin
        pop(v);
        if (q.size() > 0) check("R1 random data", v, {8'h00, q.pop_front()});
        else check("R11 random empty read", v, 16'h0000);
      end else begin
        peek(3'd1, v); check("R2 random flags", v, exp_flags());
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule